// File: doc/BRIEF.md
# Lower-Half Bank Mapper with One-Shot Boot ROM Disable

This block sits between an 8-bit CPU with a 16-bit address bus and a 128K RAM arranged as four 32K blocks. Block 0 is at the lowest physical address and block 3 is at the highest. The block produces the two upper physical RAM address bits, the RAM chip select and the boot ROM select.

The upper half of the CPU space (CPU A15 = 1) always reaches block 3. The lower half reaches the block named by a two-bit bank field. A write-only I/O register loads that field. The same register also carries a boot ROM disable bit. Once that bit has been written as 1, the ROM stays off until the next reset.

While the ROM is on, memory reads in the lower half go to the ROM instead of RAM. Memory writes in the lower half always go to RAM. This lets a boot image copy itself into RAM and then switch the ROM out.

All CPU strobes are active low. The register loads on the rising clock edge while a qualified I/O write is present. The address and select outputs are combinational from the CPU address, the strobes and the register state. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `membank_ctrl`

## Requirements
- R1: After reset, the bank field is 3 and the boot ROM is enabled. A lower-half memory read then gives ram_hi = 2'b11, ram_cs_n = 1 and rom_cs_n = 0.
- R2: Any memory access with CPU A15 = 1 gives ram_hi = 2'b11, whatever the bank field holds.
- R3: A memory access with CPU A15 = 0 gives ram_hi equal to the bank field. Bank value 0 selects the lowest block.
- R4: The register loads data bits [1:0] into the bank field on a clock edge only when all of the following hold: iorq_n = 0, wr_n = 0, m1_n = 1, and CPU address bits [7:0] = 0x1F. Address bits [15:8] are not compared.
- R5: An I/O cycle with a different low address byte has no effect on the bank field or the ROM state. So does a cycle with m1_n = 0, an I/O read, or a memory write to address 0x001F.
- R6: A register write with data bit 7 = 1 disables the boot ROM. A register write with bit 7 = 0 leaves the ROM enabled.
- R7: Once the ROM is disabled, later register writes never enable it again, whatever their bit 7. Those writes still update the bank field.
- R8: While the ROM is enabled, a lower-half memory read gives rom_cs_n = 0 and ram_cs_n = 1. A lower-half memory write gives ram_cs_n = 0 and rom_cs_n = 1. The two selects are never low together.
- R9: When mreq_n = 1, both ram_cs_n and rom_cs_n are 1. Upper-half memory reads always select RAM. With the ROM disabled, lower-half reads select RAM.
- R10: A reset after the ROM has been disabled enables it again and sets the bank field back to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge cycle, active low |
| ram_hi | output | 2 | Physical RAM address bits 16:15 |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, a two-bit bank field, port 0x1F, and the ROM disable on data bit 7. These values make all four RAM blocks reachable in the lower half. They also let the bench test a matching low address byte with a non-zero high byte, and the one-way ROM disable followed by a second reset. Every decode qualifier is tested on its own against the register. Its effect is observed only through ram_hi and the two selects.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  // CPU bus strobes after conversion to active-high form
  typedef struct packed {
    logic iorq;
    logic mreq;
    logic rd;
    logic wr;
    logic m1;
  } cpu_strb_t;

endpackage

// File: rtl/bank_io_decode.sv
module bank_io_decode
  import bankmap_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h1F
) (
  input  logic [PORT_W-1:0] port_i,
  input  cpu_strb_t         strb_i,
  output logic              reg_we_o
);

  logic unused_strb;
  assign unused_strb = strb_i.mreq ^ strb_i.rd;

  // Qualified I/O write: an interrupt acknowledge also asserts IORQ, so M1 is excluded
  always_comb begin
    reg_we_o = strb_i.iorq && strb_i.wr && !strb_i.m1 && (port_i == PORT_ADDR);
  end

endmodule

// File: rtl/bank_state_reg.sv
module bank_state_reg #(
  parameter int DATA_W      = 8,
  parameter int BANK_W      = 2,
  parameter int ROM_OFF_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              rom_en_o
);

  localparam logic [BANK_W-1:0] BANK_RST = '1;

  logic unused_data;
  assign unused_data = ^data_i;

  logic [BANK_W-1:0] bank_q;
  logic              rom_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= BANK_RST;
    end else if (we_i) begin
      bank_q <= data_i[BANK_W-1:0];
    end
  end

  // One-way flag: it can only fall, and only reset raises it again
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_en_q <= 1'b1;
    end else if (we_i && data_i[ROM_OFF_BIT]) begin
      rom_en_q <= 1'b0;
    end
  end

  assign bank_o   = bank_q;
  assign rom_en_o = rom_en_q;

endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bankmap_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              upper_i,
  input  cpu_strb_t         strb_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              rom_en_i,
  output logic [BANK_W-1:0] ram_hi_o,
  output logic              ram_cs_n_o,
  output logic              rom_cs_n_o
);

  localparam logic [BANK_W-1:0] TOP_BLOCK = '1;

  logic unused_strb;
  assign unused_strb = strb_i.iorq ^ strb_i.wr ^ strb_i.m1;

  logic rom_hit;

  always_comb begin
    ram_hi_o   = upper_i ? TOP_BLOCK : bank_i;
    rom_hit    = strb_i.mreq && strb_i.rd && rom_en_i && !upper_i;
    rom_cs_n_o = !rom_hit;
    ram_cs_n_o = !(strb_i.mreq && !rom_hit);
  end

endmodule

// File: rtl/membank_ctrl.sv
module membank_ctrl
  import bankmap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PORT_W      = 8,
  parameter int BANK_W      = 2,
  parameter int ROM_OFF_BIT = 7,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic [BANK_W-1:0] ram_hi,
  output logic              ram_cs_n,
  output logic              rom_cs_n
);

  cpu_strb_t         strb;
  logic              reg_we;
  logic [BANK_W-1:0] bank_q;
  logic              rom_en;
  logic              unused_addr;

  assign unused_addr = ^cpu_addr;

  always_comb begin
    strb.iorq = !iorq_n;
    strb.mreq = !mreq_n;
    strb.rd   = !rd_n;
    strb.wr   = !wr_n;
    strb.m1   = !m1_n;
  end

  bank_io_decode #(
    .PORT_W   (PORT_W),
    .PORT_ADDR(PORT_ADDR)
  ) u_dec (
    .port_i  (cpu_addr[PORT_W-1:0]),
    .strb_i  (strb),
    .reg_we_o(reg_we)
  );

  bank_state_reg #(
    .DATA_W     (DATA_W),
    .BANK_W     (BANK_W),
    .ROM_OFF_BIT(ROM_OFF_BIT)
  ) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (reg_we),
    .data_i  (cpu_data),
    .bank_o  (bank_q),
    .rom_en_o(rom_en)
  );

  bank_addr_map #(
    .BANK_W(BANK_W)
  ) u_map (
    .upper_i   (cpu_addr[ADDR_W-1]),
    .strb_i    (strb),
    .bank_i    (bank_q),
    .rom_en_i  (rom_en),
    .ram_hi_o  (ram_hi),
    .ram_cs_n_o(ram_cs_n),
    .rom_cs_n_o(rom_cs_n)
  );

endmodule

// File: rtl/membank_chk.sv
module membank_chk #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int PORT_W      = 8,
  parameter int BANK_W      = 2,
  parameter int ROM_OFF_BIT = 7,
  parameter logic [PORT_W-1:0] PORT_ADDR = 8'h1F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_data,
  input logic              iorq_n,
  input logic              mreq_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic [BANK_W-1:0] ram_hi,
  input logic              ram_cs_n,
  input logic              rom_cs_n,
  input logic [BANK_W-1:0] bank_q,
  input logic              rom_en
);

  logic port_write;
  assign port_write = !iorq_n && !wr_n && m1_n && (cpu_addr[PORT_W-1:0] == PORT_ADDR);

  AST_UPPER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && cpu_addr[ADDR_W-1]) |-> (ram_hi == {BANK_W{1'b1}})) else $error("upper map");  // R2

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    port_write |=> (bank_q == $past(cpu_data[BANK_W-1:0]))) else $error("bank load");  // R4

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !port_write |=> $stable(bank_q)) else $error("bank hold");  // R5

  AST_ROM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |=> !rom_en) else $error("rom sticky");  // R7

  AST_ROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (port_write && cpu_data[ROM_OFF_BIT]) |=> !rom_en) else $error("rom off");  // R6

  AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ram_cs_n && !rom_cs_n)) else $error("both selects");  // R8

  AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (ram_cs_n && rom_cs_n)) else $error("idle select");  // R9

endmodule

bind membank_ctrl membank_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PORT_W     (PORT_W),
  .BANK_W     (BANK_W),
  .ROM_OFF_BIT(ROM_OFF_BIT),
  .PORT_ADDR  (PORT_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cpu_addr(cpu_addr),
  .cpu_data(cpu_data),
  .iorq_n  (iorq_n),
  .mreq_n  (mreq_n),
  .wr_n    (wr_n),
  .m1_n    (m1_n),
  .ram_hi  (ram_hi),
  .ram_cs_n(ram_cs_n),
  .rom_cs_n(rom_cs_n),
  .bank_q  (bank_q),
  .rom_en  (rom_en)
);

// File: tb/sim_membank_ctrl.sv
`timescale 1ns/1ps
module sim_membank_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [1:0]  ram_hi;
  logic        ram_cs_n, rom_cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  membank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .ram_hi(ram_hi), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
  );

  // Compares {ram_hi, ram_cs_n, rom_cs_n}
  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    iorq_n = 1; mreq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
  endtask

  // Holds an I/O-type cycle across one rising edge
  task automatic io_cycle(input logic [15:0] a, input logic [7:0] d,
                          input bit wr, input bit m1);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; iorq_n = 0;
    wr_n = !wr; rd_n = wr; m1_n = !m1;
    @(negedge clk);
    idle();
  endtask

  // Memory access, outputs sampled mid-phase
  task automatic mem_probe(input logic [15:0] a, input bit rd, input string req,
                           input logic [3:0] exp);
    @(negedge clk);
    cpu_addr = a; mreq_n = 0; rd_n = !rd; wr_n = rd;
    #1;
    check(req, {ram_hi, ram_cs_n, rom_cs_n}, exp);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    mem_probe(16'h0100, 1, "R1 reset read", 4'b11_1_0);
    mem_probe(16'h0100, 0, "R8 rom-on write low", 4'b11_0_1);
    mem_probe(16'hC000, 1, "R9 upper read", 4'b11_0_1);
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) begin
      io_cycle(16'h001F, 8'(b), 1, 0);
      mem_probe(16'h1234, 0, "R3 low write bank", {2'(b), 2'b01});
      mem_probe(16'h1234, 1, "R6 bit7=0 keeps rom", {2'(b), 2'b10});
      mem_probe(16'hFFFF, 0, "R2 upper fixed", 4'b11_0_1);
    end
  endtask

  task automatic t_ignored();
    io_cycle(16'h001F, 8'h01, 1, 0);
    io_cycle(16'h001E, 8'h82, 1, 0);   // wrong port
    io_cycle(16'h001F, 8'h82, 1, 1);   // M1 asserted
    io_cycle(16'h001F, 8'h82, 0, 0);   // I/O read
    @(negedge clk);                     // memory write to 0x001F
    cpu_addr = 16'h001F; cpu_data = 8'h82; mreq_n = 0; wr_n = 0;
    @(negedge clk);
    idle();
    mem_probe(16'h0200, 1, "R5 ignored cycles", 4'b01_1_0);
    io_cycle(16'h551F, 8'h02, 1, 0);   // upper byte not compared
    mem_probe(16'h0200, 0, "R4 high byte ignored", 4'b10_0_1);
    mem_probe(16'h0200, 0, "R9 idle", 4'b10_0_1);
    @(negedge clk); cpu_addr = 16'h0200; #1;
    check("R9 no mreq", {ram_hi, ram_cs_n, rom_cs_n}, 4'b10_1_1);
  endtask

  task automatic t_disable();
    io_cycle(16'h001F, 8'h82, 1, 0);
    mem_probe(16'h0000, 1, "R6 rom disabled", 4'b10_0_1);
    io_cycle(16'h001F, 8'h01, 1, 0);
    mem_probe(16'h0000, 1, "R7 stays off", 4'b01_0_1);
    io_cycle(16'h001F, 8'h83, 1, 0);
    mem_probe(16'h7FFF, 1, "R7 bank still loads", 4'b11_0_1);
  endtask

  task automatic t_reset_again();
    io_cycle(16'h001F, 8'h80, 1, 0);
    do_reset();
    mem_probe(16'h0040, 1, "R10 rom back on", 4'b11_1_0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset_state();
    t_banks();
    t_ignored();
    t_disable();
    t_reset_again();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule